// File: doc/BRIEF.md
# Serial EEPROM Responder

This block stands in for a small serial EEPROM of sixty-four 16-bit words. A host drives it through bit-banged pins: a select line, a serial clock and a data-in line. It answers on a registered data-out line. A rising edge of the serial clock while the device is selected is one strobe. A strobe moves exactly one bit, either into the device from data-in or out of the device onto data-out.

Each transaction starts with a 9-bit command: a 3-bit opcode and a 6-bit word address, both sent MSB first. A read then shifts the addressed word out over 16 strobes. A write then takes 16 data bits in and stores them. Write-enable, erase and every other opcode are accepted and do nothing. After any transaction the device waits for the next command. Dropping select abandons the transaction in progress.

The word storage is loaded through a side port while the synchronous reset is held.

Top module: `seeprom_slave`

## Requirements
- R1: While and after a synchronous reset, data-out is 0 and the device waits for a command, so a read issued straight after reset returns the correct word.
- R2: Writes on the init port (init_we, init_addr, init_data) while rst is high set the stored words, and later reads return them.
- R3: The command is 9 bits sent MSB first: opcode[2:0] and then address[5:0]. Opcode 3'b110 is a read. The 16 strobes after it place word bits 15 down to 0 on dout, one bit per strobe.
- R4: dout is registered. It changes only at a clock edge where a strobe occurs and holds its value at all other times.
- R5: After the 16th bit of a read, or the 16th bit of a write, the device is back in command mode. A new command can follow at once, without a deselect.
- R6: Opcode 3'b101 is a write. The next 16 strobes take data-in MSB first, and the word is stored at the latched address after the 16th bit.
- R7: Opcode 3'b100 (write-enable) changes neither the storage nor dout, and the device returns to command mode after its 9th bit.
- R8: Opcode 3'b111 (erase) and opcodes 3'b000 to 3'b011 change neither the storage nor dout, and the device returns to command mode.
- R9: Driving cs low abandons any partial command, write or read. No word is stored, dout holds its value, and the next command after cs goes high again is decoded from its first bit.
- R10: A strobe needs a low-to-high sk transition while cs is high. Toggling sk with cs low has no effect, and holding sk high counts as a single strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; sk is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high; enables the init port |
| cs | input | 1 | Device select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data into the device |
| init_we | input | 1 | Init write strobe, honoured only while rst is high |
| init_addr | input | 6 | Init word address |
| init_data | input | 16 | Init word value |
| dout | output | 1 | Registered serial data out |

## Verification
The assertions assume that sk, cs and di are synchronous to clk and that sk stays at each level for at least one clock. They also assume that rst is held high at time zero, so every register has a defined value before the first checked cycle. The bench meets these conditions by changing every input only on the falling clock edge and by holding each sk level for at least one full clock period. While select is low, the bench also toggles sk freely and raises select while sk is already high, to probe the edge rule.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

    localparam int OP_W = 3;

    localparam logic [OP_W-1:0] OP_READ  = 3'b110;
    localparam logic [OP_W-1:0] OP_WRITE = 3'b101;

    typedef enum logic [1:0] {
        MODE_CMD = 2'd0,
        MODE_IN  = 2'd1,
        MODE_OUT = 2'd2
    } mode_e;

endpackage

// File: rtl/seeprom_strobe.sv
module seeprom_strobe (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sk,
    output logic strobe
);

    logic sk_d, sk_q;

    always_comb begin
        sk_d   = sk;
        strobe = cs && sk && !sk_q;
    end

    always_ff @(posedge clk) begin
        if (rst) sk_q <= 1'b1;
        else     sk_q <= sk_d;
    end

endmodule

// File: rtl/seeprom_store.sv
module seeprom_store #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_we,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic [WORD_W-1:0] init_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    logic init_ok, wr_ok, rd_ok;

    always_comb begin
        init_ok = int'(init_addr) < DEPTH;
        wr_ok   = int'(wr_addr) < DEPTH;
        rd_ok   = int'(rd_addr) < DEPTH;
        rd_data = rd_ok ? mem_q[rd_addr] : '0;
    end

    // Storage array: init port owns it during reset, the shifter after.
    always_ff @(posedge clk) begin
        if (rst) begin
            if (init_we && init_ok) mem_q[init_addr] <= init_data;
        end else if (wr_en && wr_ok) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // R6: a completed write frame leaves the shifted word in place.
    p_store_word_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ok) |=> (mem_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/seeprom_fsm.sv
module seeprom_fsm
    import seeprom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              strobe,
    input  logic              di,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              dout
);

    localparam int CMD_W = OP_W + ADDR_W;
    localparam int MAX_W = (CMD_W > WORD_W) ? CMD_W : WORD_W;
    localparam int CNT_W = $clog2(MAX_W + 1);
    localparam logic [CNT_W-1:0] CMD_BITS  = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] WORD_BITS = CNT_W'(WORD_W);

    typedef struct packed {
        mode_e             mode;
        logic [CNT_W-1:0]  bits;
        logic [CMD_W-1:0]  opaddr;
        logic [WORD_W-1:0] shreg;
        logic              dout;
    } fsm_t;

    fsm_t d, q;

    logic [CMD_W-1:0]  cmd_next;
    logic [WORD_W-1:0] in_next;
    logic              last_bit;

    always_comb begin
        d        = q;
        cmd_next = {q.opaddr[CMD_W-2:0], di};
        in_next  = {q.shreg[WORD_W-2:0], di};
        last_bit = (q.bits == CNT_W'(1));
        rd_addr  = cmd_next[ADDR_W-1:0];
        wr_en    = 1'b0;
        wr_addr  = q.opaddr[ADDR_W-1:0];
        wr_data  = in_next;

        if (!cs) begin
            d.mode   = MODE_CMD;
            d.bits   = CMD_BITS;
            d.opaddr = '0;
        end else if (strobe && q.bits != '0) begin
            d.bits = q.bits - CNT_W'(1);
            unique case (q.mode)
                MODE_OUT: begin
                    d.dout  = q.shreg[WORD_W-1];
                    d.shreg = {q.shreg[WORD_W-2:0], 1'b0};
                    if (last_bit) begin
                        d.mode   = MODE_CMD;
                        d.bits   = CMD_BITS;
                        d.opaddr = '0;
                    end
                end
                MODE_IN: begin
                    d.shreg = in_next;
                    if (last_bit) begin
                        wr_en    = (q.opaddr[CMD_W-1 -: OP_W] == OP_WRITE);
                        d.mode   = MODE_CMD;
                        d.bits   = CMD_BITS;
                        d.opaddr = '0;
                    end
                end
                default: begin
                    d.opaddr = cmd_next;
                    if (last_bit) begin
                        if (cmd_next[CMD_W-1 -: OP_W] == OP_READ) begin
                            d.mode  = MODE_OUT;
                            d.bits  = WORD_BITS;
                            d.shreg = rd_data;
                        end else if (cmd_next[CMD_W-1 -: OP_W] == OP_WRITE) begin
                            d.mode  = MODE_IN;
                            d.bits  = WORD_BITS;
                            d.shreg = '0;
                        end else begin
                            d.mode   = MODE_CMD;
                            d.bits   = CMD_BITS;
                            d.opaddr = '0;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.mode   <= MODE_CMD;
            q.bits   <= CMD_BITS;
            q.opaddr <= '0;
            q.shreg  <= '0;
            q.dout   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign dout = q.dout;

    // R1: leaving reset, the shifter waits for a fresh 9-bit command.
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q.mode == MODE_CMD && q.bits == CMD_BITS && !q.dout));

    // R4: without a strobe the output bit keeps its value.
    p_dout_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(q.dout));

    // R5: the remaining-bit counter never runs empty or past a word.
    p_cnt_range_r5: assert property (@(posedge clk) disable iff (rst)
        (q.bits != '0) && (q.bits <= WORD_BITS));

    // R9: a deselected cycle leaves the device in command mode with a clean frame.
    p_abort_r9: assert property (@(posedge clk) disable iff (rst)
        !cs |=> (q.mode == MODE_CMD && q.bits == CMD_BITS && q.opaddr == '0));

endmodule

// File: rtl/seeprom_slave.sv
module seeprom_slave
    import seeprom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              sk,
    input  logic              di,
    input  logic              init_we,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic [WORD_W-1:0] init_data,
    output logic              dout
);

    logic              strobe;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_data;

    seeprom_strobe u_strobe (
        .clk    (clk),
        .rst    (rst),
        .cs     (cs),
        .sk     (sk),
        .strobe (strobe)
    );

    seeprom_fsm #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .cs      (cs),
        .strobe  (strobe),
        .di      (di),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dout    (dout)
    );

    seeprom_store #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .init_we   (init_we),
        .init_addr (init_addr),
        .init_data (init_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    // R10: no strobe reaches the shifter while the device is deselected.
    p_strobe_needs_cs_r10: assert property (@(posedge clk) disable iff (rst)
        !cs |=> $stable(dout));

endmodule

// File: tb/test_seeprom_slave.sv
module test_seeprom_slave;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b0;
    logic        sk = 1'b0;
    logic        di = 1'b0;
    logic        init_we = 1'b0;
    logic [5:0]  init_addr = '0;
    logic [15:0] init_data = '0;
    logic        dout;

    int    vectors = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    live = 1'b0;
    string cur_req = "R1";

    logic [15:0] ref_mem [64];
    logic        exp_do = 1'b0;
    logic        exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    seeprom_slave i_seeprom_slave (
        .clk       (clk),
        .rst       (rst),
        .cs        (cs),
        .sk        (sk),
        .di        (di),
        .init_we   (init_we),
        .init_addr (init_addr),
        .init_data (init_data),
        .dout      (dout)
    );

    // Cycle-by-cycle comparison of the serial output against the model.
    always @(negedge clk) begin
        if (live && !done) begin
            vectors++;
            if (dout !== exp_do) begin
                errors++;
                $display("FAIL %s cycle compare: dout=%b expected %b", cur_req, dout, exp_do);
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic strobe(input logic b);
        @(negedge clk);
        di = b;
        sk = 1'b1;
        @(posedge clk);
        #1;
        if (exp_q.size() > 0) exp_do = exp_q.pop_front();
        @(negedge clk);
        sk = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic select();
        @(negedge clk);
        cs = 1'b1;
    endtask

    task automatic deselect();
        @(negedge clk);
        cs = 1'b0;
        @(posedge clk);
        #1;
        exp_q.delete();
    endtask

    task automatic send_cmd(input logic [2:0] op, input logic [5:0] a);
        logic [8:0] c;
        c = {op, a};
        for (int i = 8; i >= 0; i--) strobe(c[i]);
    endtask

    task automatic read_word(input logic [5:0] a, output logic [15:0] w);
        send_cmd(3'b110, a);
        for (int i = 15; i >= 0; i--) exp_q.push_back(ref_mem[a][i]);
        w = '0;
        for (int i = 0; i < 16; i++) begin
            strobe(1'b0);
            w = {w[14:0], dout};
        end
    endtask

    task automatic write_word(input logic [5:0] a, input logic [15:0] v);
        send_cmd(3'b101, a);
        for (int i = 15; i >= 0; i--) strobe(v[i]);
        ref_mem[a] = v;
    endtask

    task automatic check_read(input string req, input logic [5:0] a);
        logic [15:0] w;
        read_word(a, w);
        chk(req, w, ref_mem[a]);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete, got hung expected done");
        finish_run();
    end

    initial begin
        logic [15:0] w;
        logic        held;

        // R2: load every word through the init port while reset is high.
        for (int i = 0; i < 64; i++) begin
            ref_mem[i] = 16'(16'h3C5A ^ (i * 16'h0321) ^ (i << 11));
            @(negedge clk);
            init_we   = 1'b1;
            init_addr = 6'(i);
            init_data = ref_mem[i];
        end
        @(negedge clk);
        init_we = 1'b0;
        chk("R1", {15'd0, dout}, 16'd0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        live = 1'b1;
        chk("R1", {15'd0, dout}, 16'd0);

        // R1 / R3: the first read after reset decodes cleanly.
        cur_req = "R3";
        select();
        check_read("R1", 6'd0);
        deselect();

        // R2 / R3: reads across the array, each in its own select window.
        cur_req = "R2";
        select(); check_read("R2", 6'd5);  deselect();
        select(); check_read("R2", 6'd63); deselect();
        select(); check_read("R3", 6'd42); deselect();

        // R5: back-to-back reads without dropping select.
        cur_req = "R5";
        select();
        check_read("R5", 6'd10);
        check_read("R5", 6'd11);
        check_read("R5", 6'd33);
        deselect();

        // R4: output holds over a long idle stretch.
        cur_req = "R4";
        held = dout;
        repeat (25) @(posedge clk);
        #1;
        chk("R4", {15'd0, dout}, {15'd0, held});

        // R6: writes and readback, including edges of the address range.
        cur_req = "R6";
        select();
        write_word(6'd7, 16'h1234);
        check_read("R6", 6'd7);
        write_word(6'd63, 16'hFFFF);
        write_word(6'd0, 16'h8001);
        check_read("R6", 6'd63);
        check_read("R6", 6'd0);
        deselect();

        // R5: a write followed at once by a write and a read.
        cur_req = "R5";
        select();
        write_word(6'd20, 16'hA55A);
        write_word(6'd21, 16'h5AA5);
        check_read("R5", 6'd20);
        check_read("R5", 6'd21);
        deselect();

        // R7: write-enable does nothing and the next command follows.
        cur_req = "R7";
        select();
        held = dout;
        send_cmd(3'b100, 6'd7);
        chk("R7", {15'd0, dout}, {15'd0, held});
        check_read("R7", 6'd7);
        deselect();

        // R8: erase and the undefined opcodes leave data and output alone.
        cur_req = "R8";
        select();
        for (int op = 0; op < 8; op++) begin
            if (op == 3'b111 || op < 4) begin
                held = dout;
                send_cmd(3'(op), 6'd7);
                chk("R8", {15'd0, dout}, {15'd0, held});
                check_read("R8", 6'd7);
            end
        end
        deselect();

        // R9: abort inside a command, a write's data and a read's data.
        cur_req = "R9";
        select();
        strobe(1'b1); strobe(1'b0); strobe(1'b1); strobe(1'b1); strobe(1'b1);
        deselect();
        select();
        check_read("R9", 6'd7);
        deselect();

        select();
        send_cmd(3'b101, 6'd7);
        for (int i = 0; i < 10; i++) strobe(1'b0);
        deselect();
        select();
        check_read("R9", 6'd7);
        deselect();

        select();
        send_cmd(3'b110, 6'd63);
        for (int i = 15; i >= 0; i--) exp_q.push_back(ref_mem[6'd63][i]);
        for (int i = 0; i < 4; i++) strobe(1'b0);
        held = dout;
        deselect();
        repeat (5) @(posedge clk);
        #1;
        chk("R9", {15'd0, dout}, {15'd0, held});
        select();
        check_read("R9", 6'd10);
        deselect();

        // R10: sk activity while deselected is ignored.
        cur_req = "R10";
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            di = 1'b1;
            sk = ~sk;
        end
        @(negedge clk);
        sk = 1'b0;
        select();
        check_read("R10", 6'd3);
        deselect();

        // R10: select raised while sk is already high gives no strobe.
        @(negedge clk);
        sk = 1'b1;
        di = 1'b1;
        select();
        repeat (3) @(negedge clk);
        sk = 1'b0;
        check_read("R10", 6'd42);

        // R10: a long high phase of sk counts as one strobe.
        begin
            logic [8:0] c;
            c = {3'b110, 6'd5};
            for (int i = 8; i >= 0; i--) begin
                @(negedge clk);
                di = c[i];
                sk = 1'b1;
                @(posedge clk);
                #1;
                repeat (4) @(negedge clk);
                sk = 1'b0;
                @(posedge clk);
                #1;
            end
            for (int i = 15; i >= 0; i--) exp_q.push_back(ref_mem[6'd5][i]);
            w = '0;
            for (int i = 0; i < 16; i++) begin
                strobe(1'b0);
                w = {w[14:0], dout};
            end
            chk("R10", w, ref_mem[6'd5]);
        end
        deselect();

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule